// File: doc/BRIEF.md
# 64-bit Integer Execute Stage

This block is the integer execute stage of a 64-bit load-store core. Each cycle it may accept one decoded operation: an operation code, two 64-bit source operands, an 8-bit literal that can stand in for the second operand, a longword/quadword width select and a destination register index. It produces the 64-bit result for arithmetic, scaled add/subtract, compare, bitwise logic, shift and conditional-move operations. It also produces a write-enable and an overflow-trap flag.

The core has no condition-code register. Compares deliver 0 or 1 as an ordinary result, and overflow is reported only by the two trapping variants. A conditional move whose test fails simply leaves the write-enable low. All outputs are registered, and they appear one clock after the operation is presented with `in_valid` high.

Operation codes (5 bits, `op_i`): 0 add, 1 sub, 2 add-trap, 3 sub-trap, 4 add b×4, 5 add b×8, 6 sub b×4, 7 sub b×8, 8 cmp eq, 9 cmp ne, 10 cmp signed le, 11 cmp signed lt, 12 cmp unsigned le, 13 cmp unsigned lt, 14 and, 15 nand, 16 or, 17 nor, 18 xor, 19 xnor, 20 shift left logical, 21 shift right logical, 22 shift right arithmetic, 23 move-if a==0, 24 move-if a!=0, 25 move-if a<0, 26 move-if a<=0, 27 move-if a>=0, 28 move-if a>0, 29 to 31 reserved.

Top module: `int_exec_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge; otherwise `out_valid` is low after that edge. While `rst_n` is low, `out_valid`, `out_wen`, `out_trap`, `out_dest` and `out_result` are all 0.
- R2: With `use_lit_i` = 1 the second operand is `lit_i` zero-extended to 64 bits, and `src_b_i` has no effect on the result.
- R3: Codes 0 and 1 with `long_i` = 0 give a + b and a − b modulo 2^64, with `out_wen` = 1 and `out_trap` = 0 even on signed overflow.
- R4: Codes 4/6 shift the second operand left by 2, and codes 5/7 shift it left by 3, before the add or subtract. These codes never raise `out_trap`.
- R5: With `long_i` = 1, codes 0 to 7 use only bits 31:0 of both operands, and the 32-bit result is sign-extended from bit 31 into bits 63:32.
- R6: Codes 2 and 3 set `out_trap` = 1 when the signed sum or difference does not fit in 32 bits (`long_i` = 1) or 64 bits (`long_i` = 0). The wrapped result is still written with `out_wen` = 1.
- R7: Codes 8 to 13 write 1 when the condition holds and 0 otherwise, so bits 63:1 are always 0.
- R8: Codes 14 to 19 give the bitwise and, nand, or, nor, xor and xnor of the two operands.
- R9: Codes 20 to 22 shift the first operand by the amount in bits 5:0 of the second operand. Bits 63:6 of the amount are ignored, and code 22 replicates bit 63.
- R10: Codes 23 to 28 test the first operand as a signed 64-bit value against zero. `out_result` carries the second operand, and `out_wen` is 1 only when the test passes.
- R11: `out_dest` is the `dest_i` of the accepted operation. Codes 0 to 22 assert `out_wen`. Reserved codes 29 to 31 give `out_wen` = 0, `out_trap` = 0 and `out_result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code |
| long_i | input | 1 | 1 selects the 32-bit (longword) form of codes 0 to 7 |
| use_lit_i | input | 1 | 1 replaces the second operand with the literal |
| lit_i | input | 8 | Literal operand, zero-extended |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand / shift amount |
| dest_i | input | 5 | Destination register index |
| out_valid | output | 1 | Registered result is valid |
| out_wen | output | 1 | Destination should be written |
| out_trap | output | 1 | Overflow trap from a trapping variant |
| out_dest | output | 5 | Destination register index |
| out_result | output | 64 | Registered result |

## Verification
The bench targets the signed extremes that expose overflow errors: maximum plus one, minimum minus one, and longword pairs whose upper halves hold garbage. A design that tested overflow at the wrong bit, or that let upper bits leak into a longword result, would flag the wrong trap or return a non-sign-extended value. Shift amounts of 64 and above catch a design that uses more than six amount bits, because it would shift everything out. Unsigned compares with the sign bit set catch signed/unsigned confusion. Failed conditional moves catch a stray write-enable. Reserved codes catch a stale result or a spurious write.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
    localparam int XLEN    = 64;
    localparam int HALF    = XLEN / 2;
    localparam int LIT_W   = 8;
    localparam int RIDX_W  = 5;
    localparam int OP_W    = 5;
    localparam int SHAMT_W = $clog2(XLEN);

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,  OP_SUB   = 5'd1,  OP_ADDV  = 5'd2,  OP_SUBV  = 5'd3,
        OP_ADD4  = 5'd4,  OP_ADD8  = 5'd5,  OP_SUB4  = 5'd6,  OP_SUB8  = 5'd7,
        OP_CEQ   = 5'd8,  OP_CNE   = 5'd9,  OP_CLE   = 5'd10, OP_CLT   = 5'd11,
        OP_CULE  = 5'd12, OP_CULT  = 5'd13,
        OP_AND   = 5'd14, OP_NAND  = 5'd15, OP_OR    = 5'd16, OP_NOR   = 5'd17,
        OP_XOR   = 5'd18, OP_XNOR  = 5'd19,
        OP_SLL   = 5'd20, OP_SRL   = 5'd21, OP_SRA   = 5'd22,
        OP_MVEQ  = 5'd23, OP_MVNE  = 5'd24, OP_MVLT  = 5'd25, OP_MVLE  = 5'd26,
        OP_MVGE  = 5'd27, OP_MVGT  = 5'd28
    } op_e;

    typedef struct packed {
        logic              valid;
        logic              wen;
        logic              trap;
        logic [RIDX_W-1:0] dest;
        logic [XLEN-1:0]   result;
    } stage_t;
endpackage

// File: rtl/iexu_bsel.sv
module iexu_bsel #(
    parameter int W   = 64,
    parameter int L_W = 8
) (
    input  logic           use_lit,
    input  logic [L_W-1:0] lit,
    input  logic [W-1:0]   reg_b,
    output logic [W-1:0]   b_out
);
    localparam int PAD = W - L_W;

    always_comb begin
        b_out = use_lit ? {{PAD{1'b0}}, lit} : reg_b;
    end
endmodule

// File: rtl/iexu_addsub.sv
module iexu_addsub
    import iexu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  op_e          op,
    input  logic         long_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    localparam int H = W / 2;

    logic [1:0]   scale;
    logic         is_sub;
    logic [W-1:0] b_scaled;
    logic [W-1:0] addend;
    logic [W-1:0] raw;
    logic         sa, sb, sr;

    always_comb begin
        unique case (op)
            OP_ADD4, OP_SUB4: scale = 2'd2;
            OP_ADD8, OP_SUB8: scale = 2'd3;
            default:          scale = 2'd0;
        endcase
        is_sub   = (op == OP_SUB) || (op == OP_SUBV) || (op == OP_SUB4) || (op == OP_SUB8);
        b_scaled = b << scale;
        addend   = is_sub ? ~b_scaled : b_scaled;
        raw      = a + addend + W'(is_sub);

        if (long_mode) begin
            sum_o = {{H{raw[H-1]}}, raw[H-1:0]};
            sa    = a[H-1];
            sb    = addend[H-1];
            sr    = raw[H-1];
        end else begin
            sum_o = raw;
            sa    = a[W-1];
            sb    = addend[W-1];
            sr    = raw[W-1];
        end
        ovf_o = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/iexu_compare.sv
module iexu_compare
    import iexu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         cmp_bit,
    output logic         move_ok
);
    logic eq, slt, ult, a_zero, a_neg;

    always_comb begin
        eq     = (a == b);
        slt    = ($signed(a) < $signed(b));
        ult    = (a < b);
        a_zero = (a == '0);
        a_neg  = a[W-1];

        unique case (op)
            OP_CEQ:  cmp_bit = eq;
            OP_CNE:  cmp_bit = !eq;
            OP_CLE:  cmp_bit = slt || eq;
            OP_CLT:  cmp_bit = slt;
            OP_CULE: cmp_bit = ult || eq;
            OP_CULT: cmp_bit = ult;
            default: cmp_bit = 1'b0;
        endcase

        unique case (op)
            OP_MVEQ: move_ok = a_zero;
            OP_MVNE: move_ok = !a_zero;
            OP_MVLT: move_ok = a_neg;
            OP_MVLE: move_ok = a_neg || a_zero;
            OP_MVGE: move_ok = !a_neg;
            OP_MVGT: move_ok = !a_neg && !a_zero;
            default: move_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/iexu_bitshift.sv
module iexu_bitshift
    import iexu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] amt;

    always_comb begin
        amt = b[SW-1:0];
        unique case (op)
            OP_AND:  res_o = a & b;
            OP_NAND: res_o = ~(a & b);
            OP_OR:   res_o = a | b;
            OP_NOR:  res_o = ~(a | b);
            OP_XOR:  res_o = a ^ b;
            OP_XNOR: res_o = ~(a ^ b);
            OP_SLL:  res_o = a << amt;
            OP_SRL:  res_o = a >> amt;
            OP_SRA:  res_o = W'($signed(a) >>> amt);
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_i,
    input  logic              long_i,
    input  logic              use_lit_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic [XLEN-1:0]   src_a_i,
    input  logic [XLEN-1:0]   src_b_i,
    input  logic [RIDX_W-1:0] dest_i,
    output logic              out_valid,
    output logic              out_wen,
    output logic              out_trap,
    output logic [RIDX_W-1:0] out_dest,
    output logic [XLEN-1:0]   out_result
);
    op_e             op_v;
    logic [XLEN-1:0] b_sel;
    logic [XLEN-1:0] as_sum;
    logic            as_ovf;
    logic            cmp_bit;
    logic            move_ok;
    logic [XLEN-1:0] ls_res;
    stage_t          stage_d, stage_q;

    assign op_v = op_e'(op_i);

    iexu_bsel #(.W(XLEN), .L_W(LIT_W)) u_bsel (
        .use_lit (use_lit_i),
        .lit     (lit_i),
        .reg_b   (src_b_i),
        .b_out   (b_sel)
    );

    iexu_addsub #(.W(XLEN)) u_addsub (
        .op        (op_v),
        .long_mode (long_i),
        .a         (src_a_i),
        .b         (b_sel),
        .sum_o     (as_sum),
        .ovf_o     (as_ovf)
    );

    iexu_compare #(.W(XLEN)) u_compare (
        .op      (op_v),
        .a       (src_a_i),
        .b       (b_sel),
        .cmp_bit (cmp_bit),
        .move_ok (move_ok)
    );

    iexu_bitshift #(.W(XLEN)) u_bitshift (
        .op    (op_v),
        .a     (src_a_i),
        .b     (b_sel),
        .res_o (ls_res)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        stage_d.wen   = 1'b0;
        stage_d.trap  = 1'b0;
        if (in_valid) begin
            stage_d.dest = dest_i;
            unique case (op_v)
                OP_ADD, OP_SUB, OP_ADD4, OP_ADD8, OP_SUB4, OP_SUB8: begin
                    stage_d.result = as_sum;
                    stage_d.wen    = 1'b1;
                end
                OP_ADDV, OP_SUBV: begin
                    stage_d.result = as_sum;
                    stage_d.wen    = 1'b1;
                    stage_d.trap   = as_ovf;
                end
                OP_CEQ, OP_CNE, OP_CLE, OP_CLT, OP_CULE, OP_CULT: begin
                    stage_d.result = {{(XLEN-1){1'b0}}, cmp_bit};
                    stage_d.wen    = 1'b1;
                end
                OP_AND, OP_NAND, OP_OR, OP_NOR, OP_XOR, OP_XNOR,
                OP_SLL, OP_SRL, OP_SRA: begin
                    stage_d.result = ls_res;
                    stage_d.wen    = 1'b1;
                end
                OP_MVEQ, OP_MVNE, OP_MVLT, OP_MVLE, OP_MVGE, OP_MVGT: begin
                    stage_d.result = b_sel;
                    stage_d.wen    = move_ok;
                end
                default: begin
                    stage_d.result = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid  = stage_q.valid;
    assign out_wen    = stage_q.wen;
    assign out_trap   = stage_q.trap;
    assign out_dest   = stage_q.dest;
    assign out_result = stage_q.result;

    // R1: one-cycle valid pipeline
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4: plain and scaled arithmetic never trap
    a_r4_no_trap_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_i <= 5'd7) && (op_i != 5'd2) && (op_i != 5'd3)) |=> !out_trap);
    // R5: longword results are sign-extended
    a_r5_long_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && long_i && (op_i <= 5'd7)) |=> (out_result[XLEN-1:HALF] == {HALF{out_result[HALF-1]}}));
    // R6: a trap always comes with a written, valid result
    a_r6_trap_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_wen && out_valid));
    // R7: compare results are 0 or 1
    a_r7_cmp_boolean: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_i >= 5'd8) && (op_i <= 5'd13)) |=> (out_result[XLEN-1:1] == '0));
    // R11: destination index travels with the result
    a_r11_dest_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dest == $past(dest_i)));
    // R11: reserved codes never write
    a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_i >= 5'd29)) |=> (!out_wen && !out_trap));
endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
    typedef struct packed {
        logic        wen;
        logic        trap;
        logic [63:0] res;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_i = '0;
    logic        long_i = 1'b0;
    logic        use_lit_i = 1'b0;
    logic [7:0]  lit_i = '0;
    logic [63:0] src_a_i = '0;
    logic [63:0] src_b_i = '0;
    logic [4:0]  dest_i = '0;
    logic        out_valid, out_wen, out_trap;
    logic [4:0]  out_dest;
    logic [63:0] out_result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    int_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
        .long_i(long_i), .use_lit_i(use_lit_i), .lit_i(lit_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .dest_i(dest_i),
        .out_valid(out_valid), .out_wen(out_wen), .out_trap(out_trap),
        .out_dest(out_dest), .out_result(out_result)
    );

    function automatic exp_t model(input logic [4:0] op, input logic lng, input logic ul,
                                   input logic [7:0] lit, input logic [63:0] a, input logic [63:0] b);
        exp_t e;
        logic [63:0] bx, bk;
        logic [64:0] w;
        longint wl;
        int a32, b32, k;
        bit neg, ovf, pass;
        e  = '0;
        bx = ul ? {56'd0, lit} : b;
        if (op <= 5'd7) begin
            k   = (op == 5'd4 || op == 5'd6) ? 4 : ((op == 5'd5 || op == 5'd7) ? 8 : 1);
            neg = (op == 5'd1 || op == 5'd3 || op == 5'd6 || op == 5'd7);
            if (lng) begin
                a32 = int'(a[31:0]);
                b32 = int'(bx[31:0]) * k;
                wl  = neg ? (longint'(a32) - longint'(b32)) : (longint'(a32) + longint'(b32));
                e.res = {{32{wl[31]}}, wl[31:0]};
                ovf = (wl[63:31] != {33{wl[31]}});
            end else begin
                bk = bx * 64'(k);
                w  = neg ? ({a[63], a} - {bk[63], bk}) : ({a[63], a} + {bk[63], bk});
                e.res = w[63:0];
                ovf = w[64] ^ w[63];
            end
            e.wen  = 1'b1;
            e.trap = (op == 5'd2 || op == 5'd3) && ovf;
        end else if (op <= 5'd13) begin
            case (op)
                5'd8:    pass = (a == bx);
                5'd9:    pass = (a != bx);
                5'd10:   pass = ($signed(a) <= $signed(bx));
                5'd11:   pass = ($signed(a) < $signed(bx));
                5'd12:   pass = (a <= bx);
                default: pass = (a < bx);
            endcase
            e.res = {63'd0, pass};
            e.wen = 1'b1;
        end else if (op <= 5'd22) begin
            case (op)
                5'd14:   e.res = a & bx;
                5'd15:   e.res = ~(a & bx);
                5'd16:   e.res = a | bx;
                5'd17:   e.res = ~(a | bx);
                5'd18:   e.res = a ^ bx;
                5'd19:   e.res = ~(a ^ bx);
                5'd20:   e.res = a << bx[5:0];
                5'd21:   e.res = a >> bx[5:0];
                default: e.res = $signed(a) >>> bx[5:0];
            endcase
            e.wen = 1'b1;
        end else if (op <= 5'd28) begin
            case (op)
                5'd23:   pass = ($signed(a) == 0);
                5'd24:   pass = ($signed(a) != 0);
                5'd25:   pass = ($signed(a) < 0);
                5'd26:   pass = ($signed(a) <= 0);
                5'd27:   pass = ($signed(a) >= 0);
                default: pass = ($signed(a) > 0);
            endcase
            e.res = bx;
            e.wen = pass;
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [4:0] op, input logic lng);
        if (op <= 5'd1)  return lng ? "R5" : "R3";
        if (op <= 5'd3)  return "R6";
        if (op <= 5'd7)  return lng ? "R5" : "R4";
        if (op <= 5'd13) return "R7";
        if (op <= 5'd19) return "R8";
        if (op <= 5'd22) return "R9";
        if (op <= 5'd28) return "R10";
        return "R11";
    endfunction

    function automatic logic [63:0] pick();
        case ($urandom % 8)
            0: return 64'd0;
            1: return 64'h7FFF_FFFF_FFFF_FFFF;
            2: return 64'h8000_0000_0000_0000;
            3: return '1;
            4: return {$urandom, 32'h7FFF_FFFF};
            5: return 64'($urandom % 200);
            default: return {$urandom, $urandom};
        endcase
    endfunction

    // Caller is at a falling edge; the result is registered at the next rising
    // edge and sampled at the following falling edge.
    task automatic run(input logic [4:0] op, input logic lng, input logic ul, input logic [7:0] lit,
                       input logic [63:0] a, input logic [63:0] b, input logic [4:0] dst,
                       input exp_t e, input string tag);
        in_valid  = 1'b1;
        op_i      = op;
        long_i    = lng;
        use_lit_i = ul;
        lit_i     = lit;
        src_a_i   = a;
        src_b_i   = b;
        dest_i    = dst;
        @(negedge clk);
        total++;
        if (!out_valid || out_wen !== e.wen || out_trap !== e.trap ||
            out_result !== e.res || out_dest !== dst) begin
            bad++;
            $display("FAIL %s op=%0d: got v=%b w=%b t=%b d=%0d r=%h exp v=1 w=%b t=%b d=%0d r=%h",
                     tag, op, out_valid, out_wen, out_trap, out_dest, out_result,
                     e.wen, e.trap, dst, e.res);
        end
    endtask

    task automatic auto_run(input logic [4:0] op, input logic lng, input logic ul, input logic [7:0] lit,
                            input logic [63:0] a, input logic [63:0] b, input logic [4:0] dst, input string tag);
        run(op, lng, ul, lit, a, b, dst, model(op, lng, ul, lit, a, b), tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        in_valid = 1'b1;
        src_a_i  = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (out_valid || out_wen || out_trap || out_dest != 0 || out_result != 0) begin
            bad++;
            $display("FAIL R1 reset: got v=%b w=%b t=%b d=%0d r=%h exp all zero",
                     out_valid, out_wen, out_trap, out_dest, out_result);
        end
        rst_n = 1'b1;

        // R2: literal replaces register operand, zero-extended
        run(5'd0, 1'b0, 1'b1, 8'hFF, 64'd1, 64'hDEAD_BEEF_0000_0000, 5'd3,
            '{1'b1, 1'b0, 64'h100}, "R2");
        run(5'd16, 1'b0, 1'b1, 8'h80, 64'd0, '1, 5'd4, '{1'b1, 1'b0, 64'h80}, "R2");
        // R3: wrap without trap
        run(5'd0, 1'b0, 1'b0, 8'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd5,
            '{1'b1, 1'b0, 64'h8000_0000_0000_0000}, "R3");
        run(5'd1, 1'b0, 1'b0, 8'd0, 64'd0, 64'd1, 5'd6, '{1'b1, 1'b0, '1}, "R3");
        // R4: scaled forms
        run(5'd5, 1'b0, 1'b0, 8'd0, 64'd10, 64'd3, 5'd7, '{1'b1, 1'b0, 64'd34}, "R4");
        run(5'd6, 1'b0, 1'b0, 8'd0, 64'd10, 64'd3, 5'd7, '{1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE}, "R4");
        run(5'd4, 1'b0, 1'b0, 8'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h4000_0000_0000_0000, 5'd7,
            '{1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF}, "R4");
        // R5: longword ignores upper halves and sign-extends
        run(5'd0, 1'b1, 1'b0, 8'd0, 64'h1234_5678_7FFF_FFFF, 64'hABCD_0000_0000_0001, 5'd8,
            '{1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000}, "R5");
        run(5'd7, 1'b1, 1'b0, 8'd0, 64'hFFFF_0000_0000_0010, 64'h0000_0001_0000_0002, 5'd8,
            '{1'b1, 1'b0, 64'd0}, "R5");
        // R6: trapping variants
        run(5'd2, 1'b0, 1'b0, 8'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd9,
            '{1'b1, 1'b1, 64'h8000_0000_0000_0000}, "R6");
        run(5'd3, 1'b0, 1'b0, 8'd0, 64'h8000_0000_0000_0000, 64'd1, 5'd9,
            '{1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF}, "R6");
        run(5'd2, 1'b1, 1'b0, 8'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 5'd9,
            '{1'b1, 1'b1, 64'hFFFF_FFFF_8000_0000}, "R6");
        run(5'd2, 1'b0, 1'b0, 8'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 5'd9,
            '{1'b1, 1'b0, 64'h0000_0000_8000_0000}, "R6");
        // R7: signed vs unsigned with the top bit set
        run(5'd13, 1'b0, 1'b0, 8'd0, 64'd1, 64'h8000_0000_0000_0000, 5'd10, '{1'b1, 1'b0, 64'd1}, "R7");
        run(5'd11, 1'b0, 1'b0, 8'd0, 64'd1, 64'h8000_0000_0000_0000, 5'd10, '{1'b1, 1'b0, 64'd0}, "R7");
        run(5'd10, 1'b0, 1'b0, 8'd0, 64'd5, 64'd5, 5'd10, '{1'b1, 1'b0, 64'd1}, "R7");
        // R8: bitwise
        run(5'd15, 1'b0, 1'b0, 8'd0, 64'hF0F0, 64'hFF00, 5'd11, '{1'b1, 1'b0, ~64'hF000}, "R8");
        run(5'd19, 1'b0, 1'b0, 8'd0, 64'hF0F0, 64'hFF00, 5'd11, '{1'b1, 1'b0, ~64'h0FF0}, "R8");
        // R9: only six amount bits used; arithmetic right keeps sign
        run(5'd20, 1'b0, 1'b0, 8'd0, 64'd1, 64'd65, 5'd12, '{1'b1, 1'b0, 64'd2}, "R9");
        run(5'd22, 1'b0, 1'b1, 8'd4, 64'h8000_0000_0000_0000, 64'd0, 5'd12,
            '{1'b1, 1'b0, 64'hF800_0000_0000_0000}, "R9");
        // R10: conditional moves
        run(5'd28, 1'b0, 1'b0, 8'd0, 64'd0, 64'd77, 5'd13, '{1'b0, 1'b0, 64'd77}, "R10");
        run(5'd26, 1'b0, 1'b0, 8'd0, 64'd0, 64'd77, 5'd13, '{1'b1, 1'b0, 64'd77}, "R10");
        run(5'd25, 1'b0, 1'b0, 8'd0, 64'd3, 64'd77, 5'd13, '{1'b0, 1'b0, 64'd77}, "R10");
        // R11: reserved codes
        run(5'd30, 1'b0, 1'b0, 8'd0, '1, '1, 5'd14, '{1'b0, 1'b0, 64'd0}, "R11");

        for (int i = 0; i < 4000; i++) begin
            logic [4:0]  op;
            logic        lng, ul;
            logic [7:0]  lit;
            logic [63:0] a, b;
            op  = 5'($urandom % 32);
            lng = 1'($urandom);
            ul  = (($urandom % 4) == 0);
            lit = 8'($urandom);
            a   = pick();
            b   = pick();
            auto_run(op, lng, ul, lit, a, b, 5'($urandom), tag_of(op, lng));
        end

        // R1: valid drops one cycle after in_valid does
        in_valid = 1'b0;
        @(negedge clk);
        total++;
        if (out_valid || out_wen || out_trap) begin
            bad++;
            $display("FAIL R1 idle: got v=%b w=%b t=%b exp 0 0 0", out_valid, out_wen, out_trap);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule